// File: doc/BRIEF.md
# Protection Unit Control Register File

This block is the configuration register file of a memory protection unit. A host drives it one access per cycle. Each access has a 32-bit access word that selects the target register, a write flag and a 32-bit write value. The block finds the target by decoding three fields of the access word. It updates the storage on a legal write, returns the stored value on a legal read, and flags any selection it does not implement.

The storage holds:
- eight region base/size registers;
- a data cacheable-bit register and an instruction cacheable-bit register;
- a write-buffer control register;
- a data permission word and an instruction permission word.

Each permission word is reachable through two views. The full view reads and writes all 32 bits as eight 4-bit region nibbles. The compact view carries only two bits per region in the low 16 bits, and the block converts between the two layouts in both directions.

All results are registered, so the response to an access appears one clock later: either a read-data strobe or a one-cycle error pulse.

Top module: `mpu_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, every stored register is zero and both `rd_valid` and `acc_err` are low.
- R2: The register group is access-word bits [19:16], the sub-operation is bits [7:5] and the index is bits [3:0]. All other access-word bits have no effect.
- R3: In group 2, sub-operation 0 selects the data cacheable register and sub-operation 1 selects the instruction cacheable register. Any other sub-operation is a fault.
- R4: Group 3 is the write-buffer control register, read and written as a full 32-bit word for every sub-operation and index.
- R5: In group 5, sub-operation 2 accesses the data permission word and sub-operation 3 the instruction permission word, as raw 32-bit values. Sub-operations 4 to 7 are faults.
- R6: A compact permission write in group 5 (sub-operation 0 for data, 1 for instruction) stores write bits [2k+1:2k] into bits [4k+1:4k] of the target word and zeroes bits [4k+3:4k+2], for k = 0..7.
- R7: A compact permission read returns bits [4k+1:4k] of the stored word in bits [2k+1:2k], with bits [31:16] zero. Sub-operation 1 reads the instruction word and sub-operation 0 the data word.
- R8: In group 6, index 0 to 7 selects the matching region register. An index of 8 or more is a fault.
- R9: Every group other than 2, 3, 5 and 6 is a fault, including group 9 with index 1.
- R10: A faulting access changes no register, raises `acc_err` for exactly one cycle in the cycle after the access, and raises no `rd_valid`.
- R11: A legal read raises `rd_valid` for one cycle in the cycle after the access, with the value in `rd_data`. `rd_data` is zero whenever `rd_valid` is low. A legal write raises neither output and is visible to the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 32 | Access word holding the group, sub-operation and index fields |
| acc_wdata | input | 32 | Write value |
| rd_valid | output | 1 | Read data valid, one cycle after a legal read |
| rd_data | output | 32 | Read value, zero when `rd_valid` is low |
| acc_err | output | 1 | One-cycle fault pulse, one cycle after an illegal access |

## Verification
The compact view is exercised with several kinds of pattern:
- Alternating and walking 2-bit codes, which show whether each region lands in its own nibble.
- Full-view writes with all four nibble bits set and then compact reads, which show that only the low pair of each nibble is gathered and that the upper half reads zero.
- A data pattern and an instruction pattern that differ, which expose a compact read returning the wrong word.

Faulting selections are placed between legal accesses and followed by read-back of every register, so a write leaking through a fault is seen. Junk bits outside the three decoded fields are set on some accesses, so a decoder that looks at the wrong bits is seen.

// File: rtl/mpu_regs_pkg.sv
// Shared types for the protection unit control register file.
// Assumes: a 32-bit access word carrying the group, sub-operation and index fields.
package mpu_regs_pkg;
    // Decoded target of one access; SEL_NONE marks an illegal selection.
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CACHE_D,
        SEL_CACHE_I,
        SEL_WBUF,
        SEL_PERM_D_CMP,
        SEL_PERM_I_CMP,
        SEL_PERM_D_FULL,
        SEL_PERM_I_FULL,
        SEL_REGION
    } sel_e;
endpackage

// File: rtl/mpu_acc_decode.sv
// Access-word decoder: maps group/sub-operation/index to a target select.
// Assumes: NUM_REGIONS <= 16 so the 4-bit index can address every region.
module mpu_acc_decode
    import mpu_regs_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [31:0] word,
    output sel_e        sel,
    output logic [3:0]  idx,
    output logic        bad
);
    logic [3:0] grp;
    logic [2:0] subop;
    logic       unused_bits;

    assign grp         = word[19:16];
    assign subop       = word[7:5];
    assign idx         = word[3:0];
    assign unused_bits = ^{word[31:20], word[15:8], word[4]};

    // Select the target register from the group and sub-operation fields.
    always_comb begin
        sel = SEL_NONE;
        unique case (grp)
            4'd2: begin
                if (subop == 3'd0)      sel = SEL_CACHE_D;
                else if (subop == 3'd1) sel = SEL_CACHE_I;
            end
            4'd3: sel = SEL_WBUF;
            4'd5: begin
                case (subop)
                    3'd0:    sel = SEL_PERM_D_CMP;
                    3'd1:    sel = SEL_PERM_I_CMP;
                    3'd2:    sel = SEL_PERM_D_FULL;
                    3'd3:    sel = SEL_PERM_I_FULL;
                    default: sel = SEL_NONE;
                endcase
            end
            4'd6: begin
                if (int'(idx) < NUM_REGIONS) sel = SEL_REGION;
            end
            default: sel = SEL_NONE;
        endcase
    end

    assign bad = (sel == SEL_NONE);
endmodule

// File: rtl/mpu_perm_view.sv
// Converts permission words between the compact (2 bits per region) and
// full (4 bits per region) layouts.
// Assumes: DATA_W >= 4 * NUM_REGIONS.
module mpu_perm_view #(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32
) (
    input  logic [DATA_W-1:0] cmp_in,
    output logic [DATA_W-1:0] full_out,
    input  logic [DATA_W-1:0] full_in,
    output logic [DATA_W-1:0] cmp_out
);
    localparam int CMP_W = 2;
    localparam int NIB_W = 4;

    // Spread each compact pair into the low half of its nibble.
    always_comb begin
        full_out = '0;
        for (int k = 0; k < NUM_REGIONS; k++) begin
            full_out[k*NIB_W +: CMP_W] = cmp_in[k*CMP_W +: CMP_W];
        end
    end

    // Gather the low pair of each nibble into the compact layout.
    always_comb begin
        cmp_out = '0;
        for (int k = 0; k < NUM_REGIONS; k++) begin
            cmp_out[k*CMP_W +: CMP_W] = full_in[k*NIB_W +: CMP_W];
        end
    end
endmodule

// File: rtl/mpu_reg_bank.sv
// Storage for the protection unit registers; one write port.
// Assumes: wdata already in full layout for permission targets.
module mpu_reg_bank
    import mpu_regs_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  sel_e                               sel,
    input  logic [3:0]                         idx,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  cache_d,
    output logic [DATA_W-1:0]                  cache_i,
    output logic [DATA_W-1:0]                  wbuf,
    output logic [DATA_W-1:0]                  perm_d,
    output logic [DATA_W-1:0]                  perm_i,
    output logic [NUM_REGIONS-1:0][DATA_W-1:0] region
);
    // Single registers: cacheable bits, write buffer, permissions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_d <= '0;
            cache_i <= '0;
            wbuf    <= '0;
            perm_d  <= '0;
            perm_i  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CACHE_D:                     cache_d <= wdata;
                SEL_CACHE_I:                     cache_i <= wdata;
                SEL_WBUF:                        wbuf    <= wdata;
                SEL_PERM_D_CMP, SEL_PERM_D_FULL: perm_d  <= wdata;
                SEL_PERM_I_CMP, SEL_PERM_I_FULL: perm_i  <= wdata;
                default: ;
            endcase
        end
    end

    // One register per region, written when its index is selected.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (!rst_n)
                region[g] <= '0;
            else if (wr_en && sel == SEL_REGION && int'(idx) == g)
                region[g] <= wdata;
        end
    end

    // R10
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cache_d) && $stable(cache_i) && $stable(wbuf)
                    && $stable(perm_d) && $stable(perm_i) && $stable(region)));
endmodule

// File: rtl/mpu_ctrl_regs.sv
// Top of the protection unit control register file: decodes each access,
// writes the bank, builds read data and registers the response.
// Assumes: one access per cycle; the response appears the following cycle.
module mpu_ctrl_regs
    import mpu_regs_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [31:0]       acc_word,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err
);
    localparam int IDX_W   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam int CMP_TOP = 2 * NUM_REGIONS;

    sel_e                              sel;
    logic [3:0]                        idx;
    logic                              bad;
    logic                              wr_en;
    logic                              cmp_sel;
    logic [DATA_W-1:0]                 wr_full, perm_src, perm_cmp, wr_value, rd_mux;
    logic [DATA_W-1:0]                 cache_d, cache_i, wbuf, perm_d, perm_i;
    logic [NUM_REGIONS-1:0][DATA_W-1:0] region;
    logic                              rd_cmp_q;

    mpu_acc_decode #(.NUM_REGIONS(NUM_REGIONS)) dec_i (
        .word (acc_word),
        .sel  (sel),
        .idx  (idx),
        .bad  (bad)
    );

    assign cmp_sel  = (sel == SEL_PERM_D_CMP) || (sel == SEL_PERM_I_CMP);
    assign perm_src = (sel == SEL_PERM_I_CMP) ? perm_i : perm_d;

    mpu_perm_view #(.NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W)) view_i (
        .cmp_in   (acc_wdata),
        .full_out (wr_full),
        .full_in  (perm_src),
        .cmp_out  (perm_cmp)
    );

    assign wr_en    = acc_valid && acc_write && !bad;
    assign wr_value = cmp_sel ? wr_full : acc_wdata;

    mpu_reg_bank #(.NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .idx     (idx),
        .wdata   (wr_value),
        .cache_d (cache_d),
        .cache_i (cache_i),
        .wbuf    (wbuf),
        .perm_d  (perm_d),
        .perm_i  (perm_i),
        .region  (region)
    );

    // Pick the read value for the decoded target.
    always_comb begin
        case (sel)
            SEL_CACHE_D:                     rd_mux = cache_d;
            SEL_CACHE_I:                     rd_mux = cache_i;
            SEL_WBUF:                        rd_mux = wbuf;
            SEL_PERM_D_CMP, SEL_PERM_I_CMP:  rd_mux = perm_cmp;
            SEL_PERM_D_FULL:                 rd_mux = perm_d;
            SEL_PERM_I_FULL:                 rd_mux = perm_i;
            SEL_REGION:                      rd_mux = region[idx[IDX_W-1:0]];
            default:                         rd_mux = '0;
        endcase
    end

    // Register the response: read strobe and data, or a fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
            rd_cmp_q <= 1'b0;
        end else begin
            rd_valid <= acc_valid && !acc_write && !bad;
            rd_data  <= (acc_valid && !acc_write && !bad) ? rd_mux : '0;
            acc_err  <= acc_valid && bad;
            rd_cmp_q <= acc_valid && !acc_write && cmp_sel;
        end
    end

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bad) |=> (acc_err && !rd_valid));
    // R11
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !bad) |=> (rd_valid && !acc_err));
    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, acc_err}));
    // R7
    cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_cmp_q) |-> (rd_data[DATA_W-1:CMP_TOP] == '0));
endmodule

// File: tb/mpu_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module mpu_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_word = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        acc_err;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // reference model state
    logic [31:0] m_cd, m_ci, m_wb, m_pd, m_pi;
    logic [31:0] m_rg [8];
    logic        exp_rv, exp_err;
    logic [31:0] exp_rd;

    always #4 clk = ~clk;

    mpu_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err)
    );

    function automatic logic [31:0] spread(input logic [31:0] v);
        logic [31:0] r = 0;
        for (int k = 0; k < 8; k++) r[4*k +: 2] = v[2*k +: 2];
        return r;
    endfunction

    function automatic logic [31:0] gather(input logic [31:0] v);
        logic [31:0] r = 0;
        for (int k = 0; k < 8; k++) r[2*k +: 2] = v[4*k +: 2];
        return r;
    endfunction

    // Reference model: applies the access sampled at this edge.
    always @(posedge clk) begin
        int g, s, x;
        bit ok;
        logic [31:0] rv;
        started = 1;
        exp_tag = cur_tag;
        exp_rv = 0; exp_err = 0; exp_rd = 0;
        if (!rst_n) begin
            m_cd = 0; m_ci = 0; m_wb = 0; m_pd = 0; m_pi = 0;
            for (int k = 0; k < 8; k++) m_rg[k] = 0;
        end else if (acc_valid) begin
            g = int'(acc_word[19:16]); s = int'(acc_word[7:5]); x = int'(acc_word[3:0]);
            ok = 1; rv = 0;
            if (g == 2 && s == 0) begin rv = m_cd; if (acc_write) m_cd = acc_wdata; end
            else if (g == 2 && s == 1) begin rv = m_ci; if (acc_write) m_ci = acc_wdata; end
            else if (g == 3) begin rv = m_wb; if (acc_write) m_wb = acc_wdata; end
            else if (g == 5 && s == 0) begin rv = gather(m_pd); if (acc_write) m_pd = spread(acc_wdata); end
            else if (g == 5 && s == 1) begin rv = gather(m_pi); if (acc_write) m_pi = spread(acc_wdata); end
            else if (g == 5 && s == 2) begin rv = m_pd; if (acc_write) m_pd = acc_wdata; end
            else if (g == 5 && s == 3) begin rv = m_pi; if (acc_write) m_pi = acc_wdata; end
            else if (g == 6 && x < 8) begin rv = m_rg[x]; if (acc_write) m_rg[x] = acc_wdata; end
            else ok = 0;
            exp_err = !ok;
            exp_rv  = ok && !acc_write;
            exp_rd  = (ok && !acc_write) ? rv : 0;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            checks += 3;
            if (rd_valid !== exp_rv) begin
                errors++; $display("FAIL %s rd_valid act=%0b exp=%0b", exp_tag, rd_valid, exp_rv);
            end
            if (acc_err !== exp_err) begin
                errors++; $display("FAIL %s acc_err act=%0b exp=%0b", exp_tag, acc_err, exp_err);
            end
            if (rd_data !== exp_rd) begin
                errors++; $display("FAIL %s rd_data act=%h exp=%h", exp_tag, rd_data, exp_rd);
            end
        end
    end

    function automatic logic [31:0] mk(input int g, input int s, input int x);
        return (32'(g) << 16) | (32'(s) << 5) | 32'(x);
    endfunction

    task automatic acc(input bit w, input int g, input int s, input int x,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        cur_tag = tag; acc_valid = 1; acc_write = w;
        acc_word = mk(g, s, x); acc_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 0; acc_write = 0; acc_word = 32'hFFFF_FFFF; acc_wdata = 32'hDEAD_BEEF;
    endtask

    task automatic read_all(input string tag);
        acc(0, 2, 0, 0, 0, tag); acc(0, 2, 1, 0, 0, tag); acc(0, 3, 0, 0, 0, tag);
        for (int s = 0; s < 4; s++) acc(0, 5, s, 0, 0, tag);
        for (int x = 0; x < 8; x++) acc(0, 6, 0, x, 0, tag);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        while (cycles < 20000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values of every register
        read_all("R1");
        // R3 cacheable registers and bad sub-operation
        acc(1, 2, 0, 0, 32'hA5A5_0001, "R3"); acc(1, 2, 1, 0, 32'h5A5A_0002, "R3");
        acc(1, 2, 2, 0, 32'hFFFF_FFFF, "R3"); acc(0, 2, 7, 0, 0, "R3");
        acc(0, 2, 0, 0, 0, "R3"); acc(0, 2, 1, 0, 0, "R3");
        // R4 write buffer through varied sub-operation and index
        acc(1, 3, 5, 9, 32'h1234_5678, "R4"); acc(0, 3, 0, 0, 0, "R4"); acc(0, 3, 7, 15, 0, "R4");
        // R5 full permission view, faults on 4..7
        acc(1, 5, 2, 0, 32'hFFFF_FFFF, "R5"); acc(1, 5, 3, 0, 32'h8421_C3E7, "R5");
        acc(0, 5, 2, 0, 0, "R5"); acc(0, 5, 3, 0, 0, "R5");
        for (int s = 4; s < 8; s++) acc(1, 5, s, 0, 32'h0, "R5");
        // R7 compact read of full-written words; instruction vs data
        acc(0, 5, 0, 0, 0, "R7"); acc(0, 5, 1, 0, 0, "R7");
        // R6 compact writes then full read-back
        acc(1, 5, 0, 0, 32'hFFFF_AAAA, "R6"); acc(0, 5, 2, 0, 0, "R6");
        acc(1, 5, 1, 0, 32'h0000_1B6C, "R6"); acc(0, 5, 3, 0, 0, "R6");
        acc(0, 5, 1, 0, 0, "R7"); acc(0, 5, 0, 0, 0, "R7");
        for (int k = 0; k < 8; k++) begin
            acc(1, 5, 0, 0, 32'h3 << (2*k), "R6"); acc(0, 5, 2, 0, 0, "R6"); acc(0, 5, 0, 0, 0, "R7");
        end
        // R8 regions, index 8 and above fault
        for (int x = 0; x < 8; x++) acc(1, 6, 0, x, 32'h1000_0001 + 32'(x) * 32'h0101_0101, "R8");
        for (int x = 8; x < 16; x++) acc(1, 6, 0, x, 32'hFFFF_FFFF, "R8");
        for (int x = 0; x < 8; x++) acc(0, 6, 3, x, 0, "R8");
        // R9 unsupported groups, including group 9 index 1
        acc(1, 9, 0, 1, 32'hFFFF_FFFF, "R9"); acc(0, 9, 0, 1, 0, "R9");
        for (int g = 0; g < 16; g++)
            if (g != 2 && g != 3 && g != 5 && g != 6) acc(1, g, 0, 0, 32'hCAFE_F00D, "R9");
        // R10 no register changed by the faults above
        read_all("R10");
        // R2 junk outside the decoded fields is ignored
        @(negedge clk);
        cur_tag = "R2"; acc_valid = 1; acc_write = 1;
        acc_word = mk(3, 1, 2) | 32'hFFF0_FF10; acc_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        cur_tag = "R2"; acc_write = 0; acc_word = mk(3, 0, 0) | 32'hABC0_5A10;
        @(negedge clk);
        cur_tag = "R2"; acc_word = mk(6, 0, 2) | 32'h7770_8810;
        // R11 back-to-back write then read, then idle strobes
        acc(1, 6, 0, 5, 32'h5555_AAAA, "R11"); acc(0, 6, 0, 5, 0, "R11");
        acc(1, 2, 0, 0, 32'h0F0F_0F0F, "R11"); acc(0, 2, 0, 0, 0, "R11");
        idle(); idle(); idle();
        // R1 reset again clears state
        @(negedge clk); rst_n = 0; cur_tag = "R1";
        @(negedge clk); @(negedge clk); rst_n = 1;
        read_all("R1");
        idle(); idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule